// File: doc/BRIEF.md
# Partitioned-Bank Memory Request Scheduler

This block chooses the next memory request to send to downstream command logic. Incoming requests carry a core number, a bank, a row and a write flag. Reads and writes wait in two separate age-ordered queues. The block grants at most one request per cycle on a valid/ready output, and a request is issued when the downstream side takes it. For each bank the block keeps the row that the last issued request used, which serves as the open row.

Configuration inputs split the banks into two groups. A reserved bank belongs to one core, named by an owner field. All other banks are shared. Reads to reserved banks have the highest rank and are granted round robin over the owning cores, which bounds the wait of each core. Shared-bank reads come next. Writes are served only in a write-drain mode. A reserved-bank read that arrives during a drain ends the drain at once.

Top module: `dsched_top`

## Requirements
- R1: Each queue holds 8 entries. When the queue selected by `in_is_wr` is full, `in_ready` is low and the request is not taken. The other queue still accepts.
- R2: A write is granted only in drain mode. Outside drain mode only reads are granted.
- R3: While any reserved-bank read is queued, no shared-bank read is granted.
- R4: Reserved-bank reads are granted round robin over their owner cores. The search starts at the pointer, which resets to 0. After such a grant the pointer moves to owner+1 (modulo 4). Cores with no pending reserved read are skipped in the same cycle. Within one core, its oldest reserved read goes first.
- R5: Writes use first-ready ordering. The oldest write whose row equals its bank's open row wins. If no write hits, the oldest write wins.
- R6: Shared-bank reads use the same first-ready ordering as writes.
- R7: Drain mode starts at the next edge if writes are queued and either the read queue is empty, or the write queue holds at least 6 entries with no reserved read queued.
- R8: Drain mode ends at the edge that closes a cycle which began with the write queue empty, or with at most 2 writes queued and a read pending. The write granted in that cycle still issues.
- R9: If a reserved-bank read is accepted during drain mode, the next cycle is in read mode.
- R10: Each issue sets its bank's open row to the row it carried. After reset every bank is closed and nothing hits.
- R11: After reset `out_valid` is low and both queues are empty and ready.
- R12: Bank b is reserved when `cfg_resv[b]` is 1. Its owner core is `cfg_owner[2*b+1:2*b]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_resv | input | 8 | Per-bank reserved flag |
| cfg_owner | input | 16 | Owner core of each bank, 2 bits per bank |
| in_valid | input | 1 | Incoming request valid |
| in_ready | output | 1 | Target queue can take the request |
| in_core | input | 2 | Requesting core |
| in_bank | input | 3 | Target bank |
| in_row | input | 8 | Target row |
| in_is_wr | input | 1 | 1 = write, 0 = read |
| out_valid | output | 1 | A granted request is offered |
| out_ready | input | 1 | Downstream accepts the offer |
| out_core | output | 2 | Core of granted request |
| out_bank | output | 3 | Bank of granted request |
| out_row | output | 8 | Row of granted request |
| out_is_wr | output | 1 | Granted request is a write |

## Verification
The bench puts reserved reads behind older shared reads. A design that ranks reads by age alone would issue the shared read first. It also loads reserved reads from cores that are not next in turn. A pointer that fails to skip idle cores, or that advances from the wrong core, would reorder the grants. Row-hit writes and shared reads sit behind older misses to catch a plain FCFS queue. A reserved read arrives during a high-watermark drain to check that reads return within one cycle and that the drain does not restart before that read has issued. A low-watermark run checks that exactly one write issues in the exit cycle. A 9th request into a full queue checks that no entry is overwritten.

// File: rtl/dsched_pkg.sv
package dsched_pkg;
    parameter int NCORE  = 4;
    parameter int NBANK  = 8;
    parameter int ROW_W  = 8;
    parameter int QDEPTH = 8;
    parameter int WM_HI  = 6;
    parameter int WM_LO  = 2;

    localparam int CORE_W = $clog2(NCORE);
    localparam int BANK_W = $clog2(NBANK);
    localparam int IDX_W  = $clog2(QDEPTH);
    localparam int CNT_W  = $clog2(QDEPTH + 1);

    typedef struct packed {
        logic [CORE_W-1:0] core;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic              is_wr;
    } mreq_t;

    function automatic logic [CORE_W-1:0] owner_of(
        input logic [NBANK*CORE_W-1:0] map,
        input logic [BANK_W-1:0]       b
    );
        return map[int'(b)*CORE_W +: CORE_W];
    endfunction
endpackage

// File: rtl/dsched_queue.sv
module dsched_queue
    import dsched_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enq_valid,
    input  mreq_t            enq_data,
    output logic             enq_ready,
    input  logic             deq,
    input  logic [IDX_W-1:0] deq_idx,
    output mreq_t            ent [QDEPTH],
    output logic [QDEPTH-1:0] vld,
    output logic [CNT_W-1:0] count
);
    logic             enq;
    logic [IDX_W-1:0] wptr;

    assign enq_ready = (count < CNT_W'(QDEPTH));
    assign enq       = enq_valid && enq_ready;
    assign wptr      = IDX_W'(count - CNT_W'(deq));

    always_comb begin
        for (int i = 0; i < QDEPTH; i++) vld[i] = (CNT_W'(i) < count);
    end

    // entry 0 is always the oldest; removal compacts younger entries down
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            if (deq) begin
                for (int i = 0; i < QDEPTH - 1; i++)
                    if (i >= int'(deq_idx)) ent[i] <= ent[i+1];
            end
            if (enq) ent[wptr] <= enq_data;
            count <= count + CNT_W'(enq) - CNT_W'(deq);
        end
    end

    a_r1_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(QDEPTH));
    a_r1_full_holds: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(QDEPTH) && !deq) |=> $stable(count));
    a_r1_no_underflow: assert property (@(posedge clk) disable iff (rst)
        deq |-> (count != '0));
endmodule

// File: rtl/dsched_frfcfs.sv
module dsched_frfcfs
    import dsched_pkg::*;
(
    input  logic [QDEPTH-1:0] cand,
    input  logic [QDEPTH-1:0] hit,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);
    logic [IDX_W-1:0] old_idx;
    logic [IDX_W-1:0] hit_idx;
    logic             any_hit;

    always_comb begin
        old_idx = '0;
        hit_idx = '0;
        any_hit = 1'b0;
        for (int i = QDEPTH - 1; i >= 0; i--) begin
            if (cand[i]) old_idx = IDX_W'(i);
            if (cand[i] && hit[i]) begin
                hit_idx = IDX_W'(i);
                any_hit = 1'b1;
            end
        end
        found = |cand;
        idx   = any_hit ? hit_idx : old_idx;
    end
endmodule

// File: rtl/dsched_top.sv
module dsched_top
    import dsched_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NBANK-1:0]        cfg_resv,
    input  logic [NBANK*CORE_W-1:0] cfg_owner,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [CORE_W-1:0]       in_core,
    input  logic [BANK_W-1:0]       in_bank,
    input  logic [ROW_W-1:0]        in_row,
    input  logic                    in_is_wr,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [CORE_W-1:0]       out_core,
    output logic [BANK_W-1:0]       out_bank,
    output logic [ROW_W-1:0]        out_row,
    output logic                    out_is_wr
);
    mreq_t             in_req;
    mreq_t             rd_ent [QDEPTH];
    mreq_t             wr_ent [QDEPTH];
    logic [QDEPTH-1:0] rd_vld, wr_vld, rd_hit, wr_hit, rd_res, rd_shr;
    logic [CNT_W-1:0]  rd_cnt, wr_cnt;
    logic              rd_rdy, wr_rdy;

    logic [ROW_W-1:0]  open_row [NBANK];
    logic [NBANK-1:0]  open_ok;
    logic [CORE_W-1:0] rr_ptr, sel_core;
    logic              drain_q, drain_n;

    logic [NCORE-1:0]  pend;
    logic [IDX_W-1:0]  pidx [NCORE];
    logic              res_any, shr_found, wr_found;
    logic [IDX_W-1:0]  shr_idx, wr_idx, gnt_idx;
    logic              gnt_wr, gnt_res, issue, res_arrive;
    mreq_t             gnt;

    assign in_req   = '{core: in_core, bank: in_bank, row: in_row, is_wr: in_is_wr};
    assign in_ready = in_is_wr ? wr_rdy : rd_rdy;

    dsched_queue u_rq (
        .clk(clk), .rst(rst), .enq_valid(in_valid && !in_is_wr), .enq_data(in_req),
        .enq_ready(rd_rdy), .deq(issue && !gnt_wr), .deq_idx(gnt_idx),
        .ent(rd_ent), .vld(rd_vld), .count(rd_cnt));

    dsched_queue u_wq (
        .clk(clk), .rst(rst), .enq_valid(in_valid && in_is_wr), .enq_data(in_req),
        .enq_ready(wr_rdy), .deq(issue && gnt_wr), .deq_idx(gnt_idx),
        .ent(wr_ent), .vld(wr_vld), .count(wr_cnt));

    // classify queued requests: open-row hit, reserved or shared
    always_comb begin
        for (int i = 0; i < QDEPTH; i++) begin
            rd_hit[i] = open_ok[rd_ent[i].bank] && (open_row[rd_ent[i].bank] == rd_ent[i].row);
            wr_hit[i] = open_ok[wr_ent[i].bank] && (open_row[wr_ent[i].bank] == wr_ent[i].row);
            rd_res[i] = rd_vld[i] && cfg_resv[rd_ent[i].bank];
            rd_shr[i] = rd_vld[i] && !cfg_resv[rd_ent[i].bank];
        end
    end

    // oldest reserved read per owner core
    always_comb begin
        for (int c = 0; c < NCORE; c++) begin
            pend[c] = 1'b0;
            pidx[c] = '0;
            for (int i = QDEPTH - 1; i >= 0; i--) begin
                if (rd_res[i] && owner_of(cfg_owner, rd_ent[i].bank) == CORE_W'(c)) begin
                    pend[c] = 1'b1;
                    pidx[c] = IDX_W'(i);
                end
            end
        end
    end

    // round robin: first pending core at or after the pointer
    always_comb begin
        sel_core = rr_ptr;
        res_any  = 1'b0;
        for (int k = NCORE - 1; k >= 0; k--) begin
            if (pend[rr_ptr + CORE_W'(k)]) begin
                sel_core = rr_ptr + CORE_W'(k);
                res_any  = 1'b1;
            end
        end
    end

    dsched_frfcfs u_shr_pick (.cand(rd_shr), .hit(rd_hit), .found(shr_found), .idx(shr_idx));
    dsched_frfcfs u_wr_pick  (.cand(wr_vld), .hit(wr_hit), .found(wr_found),  .idx(wr_idx));

    always_comb begin
        out_valid = 1'b0;
        gnt_wr    = 1'b0;
        gnt_res   = 1'b0;
        gnt_idx   = '0;
        gnt       = '0;
        if (drain_q) begin
            out_valid = wr_found;
            gnt_wr    = 1'b1;
            gnt_idx   = wr_idx;
            gnt       = wr_ent[wr_idx];
        end else if (res_any) begin
            out_valid = 1'b1;
            gnt_res   = 1'b1;
            gnt_idx   = pidx[sel_core];
            gnt       = rd_ent[pidx[sel_core]];
        end else if (shr_found) begin
            out_valid = 1'b1;
            gnt_idx   = shr_idx;
            gnt       = rd_ent[shr_idx];
        end
    end

    assign out_core  = gnt.core;
    assign out_bank  = gnt.bank;
    assign out_row   = gnt.row;
    assign out_is_wr = gnt_wr;
    assign issue     = out_valid && out_ready;

    assign res_arrive = in_valid && rd_rdy && !in_is_wr && cfg_resv[in_bank];

    always_comb begin
        drain_n = drain_q;
        if (!drain_q) begin
            if (wr_cnt != '0 &&
                (rd_cnt == '0 || (wr_cnt >= CNT_W'(WM_HI) && !res_any)))
                drain_n = 1'b1;
        end else if (res_arrive || wr_cnt == '0 ||
                     (wr_cnt <= CNT_W'(WM_LO) && rd_cnt != '0)) begin
            drain_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drain_q <= 1'b0;
            rr_ptr  <= '0;
            open_ok <= '0;
            for (int b = 0; b < NBANK; b++) open_row[b] <= '0;
        end else begin
            drain_q <= drain_n;
            if (issue) begin
                open_ok[gnt.bank]  <= 1'b1;
                open_row[gnt.bank] <= gnt.row;
                if (gnt_res) rr_ptr <= sel_core + CORE_W'(1);
            end
        end
    end

    a_r2_write_only_in_drain: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_wr) |-> drain_q);
    a_r3_reserved_first: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_wr && !cfg_resv[out_bank]) |-> (rd_res == '0));
    a_r4_rr_advance: assert property (@(posedge clk) disable iff (rst)
        (issue && !out_is_wr && cfg_resv[out_bank])
        |=> (rr_ptr == $past(owner_of(cfg_owner, out_bank)) + CORE_W'(1)));
    a_r9_preempt: assert property (@(posedge clk) disable iff (rst)
        (drain_q && res_arrive) |=> !drain_q);
    a_r10_open_row: assert property (@(posedge clk) disable iff (rst)
        issue |=> (open_ok[$past(out_bank)] && open_row[$past(out_bank)] == $past(out_row)));
endmodule

// File: tb/dsched_top_bench.sv
module dsched_top_bench;
    import dsched_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NBANK-1:0]        cfg_resv  = 8'h0F;
    logic [NBANK*CORE_W-1:0] cfg_owner = 16'b00_00_00_00_11_10_01_00;
    logic in_valid = 1'b0, in_is_wr = 1'b0, out_ready = 1'b0;
    logic [CORE_W-1:0] in_core = '0;
    logic [BANK_W-1:0] in_bank = '0;
    logic [ROW_W-1:0]  in_row  = '0;
    logic in_ready, out_valid, out_is_wr;
    logic [CORE_W-1:0] out_core;
    logic [BANK_W-1:0] out_bank;
    logic [ROW_W-1:0]  out_row;

    int n_chk = 0;
    int n_bad = 0;
    mreq_t exp_q [$];
    string exp_tag [$];

    always #5 clk = ~clk;

    dsched_top u_dsched_top (
        .clk(clk), .rst(rst), .cfg_resv(cfg_resv), .cfg_owner(cfg_owner),
        .in_valid(in_valid), .in_ready(in_ready), .in_core(in_core),
        .in_bank(in_bank), .in_row(in_row), .in_is_wr(in_is_wr),
        .out_valid(out_valid), .out_ready(out_ready), .out_core(out_core),
        .out_bank(out_bank), .out_row(out_row), .out_is_wr(out_is_wr));

    function automatic mreq_t mk(input int c, input int b, input int r, input bit w);
        return '{core: CORE_W'(c), bank: BANK_W'(b), row: ROW_W'(r), is_wr: w};
    endfunction

    task automatic check(input bit ok, input string tag, input string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    task automatic expect_issue(input string tag, input int c, input int b, input int r, input bit w);
        exp_q.push_back(mk(c, b, r, w));
        exp_tag.push_back(tag);
    endtask

    // called just after a rising edge; holds the request for one cycle
    task automatic enq(input int c, input int b, input int r, input bit w, input bit want_acc, input string tag);
        bit acc;
        in_valid = 1'b1; in_core = CORE_W'(c); in_bank = BANK_W'(b);
        in_row = ROW_W'(r); in_is_wr = w;
        @(negedge clk);
        acc = in_ready;
        check(acc == want_acc, tag, $sformatf("accept actual=%0b expected=%0b", acc, want_acc));
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic run_out(input string tag);
        out_ready = 1'b1;
        for (int n = 0; n < 100 && (exp_q.size() != 0 || out_valid); n++) begin
            @(posedge clk); #1;
        end
        out_ready = 1'b0;
        check(exp_q.size() == 0, tag, $sformatf("pending actual=%0d expected=0", exp_q.size()));
        exp_q.delete();
        exp_tag.delete();
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            mreq_t got;
            got = mk(int'(out_core), int'(out_bank), int'(out_row), out_is_wr);
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL issue: actual=%p expected=none", got);
            end else begin
                mreq_t want;
                string t;
                want = exp_q.pop_front();
                t = exp_tag.pop_front();
                if (got != want) begin
                    n_bad++;
                    $display("FAIL %s: actual=%p expected=%p", t, got, want);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!out_valid, "R11", $sformatf("out_valid actual=%0b expected=0", out_valid));
        check(in_ready, "R11", $sformatf("in_ready actual=%0b expected=1", in_ready));
        @(posedge clk); #1;

        // A: reserved before older shared (R3, R12), round robin (R4), shared FR-FCFS (R6, R10)
        enq(0, 5, 10, 0, 1, "R11");
        enq(1, 1, 1, 0, 1, "R11");
        enq(2, 2, 2, 0, 1, "R11");
        enq(0, 0, 3, 0, 1, "R11");
        enq(3, 6, 20, 0, 1, "R11");
        enq(1, 5, 10, 0, 1, "R11");
        @(negedge clk);
        check(out_valid && out_bank == 0, "R3", $sformatf("first bank actual=%0d expected=0", out_bank));
        @(posedge clk); #1;
        expect_issue("R4", 0, 0, 3, 0);
        expect_issue("R4", 1, 1, 1, 0);
        expect_issue("R4", 2, 2, 2, 0);
        expect_issue("R10", 0, 5, 10, 0);
        expect_issue("R6", 1, 5, 10, 0);
        expect_issue("R6", 3, 6, 20, 0);
        run_out("R3");

        // B: full read queue (R1), pointer skips idle cores (R4)
        enq(1, 1, 1, 0, 1, "R1");
        enq(1, 1, 5, 0, 1, "R1");
        enq(3, 3, 7, 0, 1, "R1");
        enq(1, 1, 6, 0, 1, "R1");
        enq(0, 4, 9, 0, 1, "R1");
        enq(0, 4, 8, 0, 1, "R1");
        enq(0, 4, 9, 0, 1, "R1");
        enq(0, 4, 8, 0, 1, "R1");
        enq(2, 7, 55, 0, 0, "R1");
        in_is_wr = 1'b1;
        @(negedge clk);
        check(in_ready, "R1", $sformatf("write ready actual=%0b expected=1", in_ready));
        @(posedge clk); #1;
        in_is_wr = 1'b0;
        expect_issue("R4", 3, 3, 7, 0);
        expect_issue("R4", 1, 1, 1, 0);
        expect_issue("R4", 1, 1, 5, 0);
        expect_issue("R4", 1, 1, 6, 0);
        expect_issue("R6", 0, 4, 9, 0);
        expect_issue("R6", 0, 4, 9, 0);
        expect_issue("R6", 0, 4, 8, 0);
        expect_issue("R6", 0, 4, 8, 0);
        run_out("R1");

        // C: writes with no reads pending drain at once, FR-FCFS order (R5, R7)
        enq(0, 6, 30, 1, 1, "R7");
        enq(1, 4, 8, 1, 1, "R7");
        enq(2, 6, 20, 1, 1, "R7");
        enq(3, 5, 11, 1, 1, "R7");
        @(negedge clk);
        check(out_valid && out_is_wr, "R7", $sformatf("drain actual=%0b expected=1", out_is_wr));
        @(posedge clk); #1;
        expect_issue("R5", 1, 4, 8, 1);
        expect_issue("R5", 2, 6, 20, 1);
        expect_issue("R5", 0, 6, 30, 1);
        expect_issue("R5", 3, 5, 11, 1);
        run_out("R5");

        // D: high watermark entry (R7), reads first before it (R2), preemption (R9)
        enq(2, 7, 1, 0, 1, "R2");
        enq(0, 7, 5, 1, 1, "R2");
        enq(0, 7, 1, 1, 1, "R2");
        enq(0, 7, 5, 1, 1, "R2");
        enq(0, 7, 1, 1, 1, "R2");
        enq(0, 7, 9, 1, 1, "R2");
        enq(1, 7, 1, 1, 1, "R2");
        @(negedge clk);
        check(out_valid && !out_is_wr, "R2", $sformatf("is_wr actual=%0b expected=0", out_is_wr));
        @(posedge clk); #1;
        @(negedge clk);
        check(out_valid && out_is_wr, "R7", $sformatf("is_wr actual=%0b expected=1", out_is_wr));
        @(posedge clk); #1;
        enq(0, 0, 3, 0, 1, "R9");
        @(negedge clk);
        check(out_valid && !out_is_wr && out_bank == 0, "R9",
              $sformatf("is_wr/bank actual=%0b/%0d expected=0/0", out_is_wr, out_bank));
        @(posedge clk); #1;
        expect_issue("R9", 0, 0, 3, 0);
        expect_issue("R3", 2, 7, 1, 0);
        expect_issue("R5", 0, 7, 1, 1);
        expect_issue("R5", 0, 7, 1, 1);
        expect_issue("R5", 1, 7, 1, 1);
        expect_issue("R5", 0, 7, 5, 1);
        expect_issue("R5", 0, 7, 5, 1);
        expect_issue("R5", 0, 7, 9, 1);
        run_out("R9");

        // E: low watermark exit with a read pending (R8)
        for (int k = 0; k < 6; k++) enq(k % 4, 4, 40 + k, 1, 1, "R8");
        enq(3, 5, 77, 0, 1, "R8");
        for (int k = 0; k < 5; k++) expect_issue("R8", k % 4, 4, 40 + k, 1);
        expect_issue("R8", 3, 5, 77, 0);
        expect_issue("R8", 1, 4, 45, 1);
        run_out("R8");

        @(negedge clk);
        check(!out_valid, "R11", $sformatf("idle out_valid actual=%0b expected=0", out_valid));
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule